// File: doc/BRIEF.md
# Speculative Store Buffer With Load Forwarding

This block keeps the results of executed but uncommitted stores in a small circular table, so that none of them reaches the data cache before the instruction is known to be safe. Stores are entered in program order. Each entry holds an address tag, a data word, an instruction number and a slot state: free, speculative or committed. A commit message moves a matching entry from speculative to committed. An abort message removes either one speculative store or every speculative store at or after a given instruction number. Committed entries leave from the head of the ring, one per cycle, to a cache write port that applies backpressure.

Loads probe the table with their address tag and instruction number. The probe compares each live entry's tag and age against the load. Among the matching stores that are strictly older than the load, the youngest one supplies the data, and the result is registered one cycle later. Instruction numbers wrap around, so age is taken from the modular difference between two numbers. Ties between several matches are broken by each entry's distance from the head pointer.

Top module: `spec_store_buf`

## Requirements
- R1: After a synchronous reset the table is empty: `st_full`, `cw_valid` and `ld_hit` are all 0.
- R2: A store with `st_valid` high is entered while fewer than DEPTH slots are in use. `st_full` is 1 exactly when all DEPTH (default 8) slots are in use. A store offered while full is dropped: it is never forwarded and never written to the cache.
- R3: A store that has not been committed is never presented on the cache write port, even when `cw_ready` is high.
- R4: Committed stores are written to the cache in the order in which they were entered, at most one per cycle, with their own tag and data on `cw_tag`/`cw_data`. A written entry no longer forwards.
- R5: While `cw_valid` is 1 and `cw_ready` is 0, the port holds `cw_valid`, `cw_tag` and `cw_data` unchanged.
- R6: An abort with `ab_younger` = 0 removes the speculative entry whose instruction number equals `ab_inum`. That store is never forwarded or written, and later entries still drain behind it.
- R7: An abort with `ab_younger` = 1 removes every speculative entry whose instruction number is equal to or younger than `ab_inum`. Older entries are kept.
- R8: A lookup in cycle n sets `ld_hit` and `ld_data` in cycle n+1 when a live entry has the same tag and is strictly older than the load. Otherwise `ld_hit` is 0.
- R9: A store with the same instruction number as the load, or a younger one, is not forwarded.
- R10: When several older stores match, the data comes from the youngest of them.
- R11: Instruction numbers compare modulo 2^INUM_W. A is older than B when (B − A) mod 2^INUM_W is nonzero and below 2^(INUM_W−1). This holds across the wrap from the largest value to 0.
- R12: A committed entry that is waiting for the cache port still forwards to loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store execute request |
| st_inum | input | INUM_W | Instruction number of the store |
| st_tag | input | TAG_W | Address tag of the store |
| st_data | input | DATA_W | Store data |
| st_full | output | 1 | All slots in use; stores are dropped |
| cm_valid | input | 1 | Commit request |
| cm_inum | input | INUM_W | Instruction number being committed |
| ab_valid | input | 1 | Abort request |
| ab_inum | input | INUM_W | Instruction number to abort |
| ab_younger | input | 1 | 1: abort this number and all younger; 0: this one only |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | TAG_W | Address tag of the load |
| ld_inum | input | INUM_W | Instruction number of the load |
| ld_hit | output | 1 | Forwarding hit, one cycle after the lookup |
| ld_data | output | DATA_W | Forwarded data |
| cw_valid | output | 1 | Committed entry offered to the cache |
| cw_ready | input | 1 | Cache accepts the write |
| cw_tag | output | TAG_W | Tag of the cache write |
| cw_data | output | DATA_W | Data of the cache write |

## Verification
The hardest case to reach from the ports combines three things. Two stores to the same tag must lie on both sides of the instruction-number wrap. The table must be completely full at the same time, and a store must be offered at that moment so that it is dropped. The stimulus holds `cw_ready` low and enters eight stores numbered 60 through 3. It places a shared tag on 62 and 1, offers a ninth store, and probes with load numbers chosen so that each of the two candidates is the correct answer once. The drain order is then checked against a log of all cache writes. The log also confirms that aborted and dropped stores never appear on the cache port.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_SPEC = 2'd1,
    SLOT_DONE = 2'd2
  } slot_e;
endpackage

// File: rtl/ssb_ring.sv
// Head/tail pointers of the entry ring, one extra bit to tell full from empty.
module ssb_ring #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + CNT_W'(1);
      if (pop)  head_q <= head_q + CNT_W'(1);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign cnt      = tail_q - head_q;
  assign full     = (cnt == CNT_W'(DEPTH));
  assign empty    = (cnt == '0);
endmodule

// File: rtl/ssb_fwd.sv
// Load probe: tag and age match per entry, youngest older match wins by ring offset.
module ssb_fwd #(
  parameter int DEPTH  = 8,
  parameter int INUM_W = 6,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DEPTH-1:0]              live,
  input  logic [DEPTH-1:0][INUM_W-1:0]  e_inum,
  input  logic [DEPTH-1:0][TAG_W-1:0]   e_tag,
  input  logic [DEPTH-1:0][DATA_W-1:0]  e_data,
  input  logic [IDX_W-1:0]              head_idx,
  input  logic                          lk_valid,
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic [INUM_W-1:0]             lk_inum,
  output logic                          hit,
  output logic [DATA_W-1:0]             data
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [INUM_W-1:0] gap;
    assign gap      = lk_inum - e_inum[g];
    // store strictly older: gap nonzero and inside the lower half of the number space
    assign match[g] = live[g] && (e_tag[g] == lk_tag) && (gap != '0) && !gap[INUM_W-1];
  end

  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] scan_idx;

  always_comb begin
    sel_hit  = 1'b0;
    sel_idx  = '0;
    scan_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scan_idx = head_idx + IDX_W'(k);
      if (match[scan_idx]) begin
        sel_hit = 1'b1;
        sel_idx = scan_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      data <= '0;
    end else begin
      hit  <= lk_valid && sel_hit;
      data <= (lk_valid && sel_hit) ? e_data[sel_idx] : '0;
    end
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int DEPTH  = 8,
  parameter int INUM_W = 6,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [INUM_W-1:0] st_inum,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_full,
  input  logic              cm_valid,
  input  logic [INUM_W-1:0] cm_inum,
  input  logic              ab_valid,
  input  logic [INUM_W-1:0] ab_inum,
  input  logic              ab_younger,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [INUM_W-1:0] ld_inum,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic [TAG_W-1:0]  cw_tag,
  output logic [DATA_W-1:0] cw_data
);
  import ssb_pkg::*;

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] cnt;
  logic             ring_full, ring_empty;
  logic             alloc, pop;

  slot_e                        slot_q [DEPTH];
  logic [DEPTH-1:0][INUM_W-1:0] inum_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             live;

  ssb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .push     (alloc),
    .pop      (pop),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .cnt      (cnt),
    .full     (ring_full),
    .empty    (ring_empty)
  );

  assign alloc   = st_valid && !ring_full;
  assign st_full = ring_full;

  // Head leaves when it is an abort hole, or committed and accepted by the cache.
  assign cw_valid = !ring_empty && (slot_q[head_idx] == SLOT_DONE);
  assign pop      = !ring_empty &&
                    ((slot_q[head_idx] == SLOT_FREE) || (cw_valid && cw_ready));
  assign cw_tag   = tag_q[head_idx];
  assign cw_data  = data_q[head_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [INUM_W-1:0] ab_gap;
    logic              ab_hit, cm_hit;

    assign ab_gap = inum_q[g] - ab_inum;
    assign cm_hit = cm_valid && (slot_q[g] == SLOT_SPEC) && (inum_q[g] == cm_inum);
    assign ab_hit = ab_valid && (slot_q[g] == SLOT_SPEC) &&
                    (ab_younger ? !ab_gap[INUM_W-1] : (inum_q[g] == ab_inum));
    assign live[g] = (slot_q[g] != SLOT_FREE);

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= SLOT_FREE;
      end else if (pop && (head_idx == IDX_W'(g))) begin
        slot_q[g] <= SLOT_FREE;
      end else if (alloc && (tail_idx == IDX_W'(g))) begin
        slot_q[g] <= SLOT_SPEC;
      end else if (ab_hit) begin
        slot_q[g] <= SLOT_FREE;
      end else if (cm_hit) begin
        slot_q[g] <= SLOT_DONE;
      end
    end

    // payload has no reset: written only on allocation
    always_ff @(posedge clk) begin
      if (alloc && (tail_idx == IDX_W'(g))) begin
        inum_q[g] <= st_inum;
        tag_q[g]  <= st_tag;
        data_q[g] <= st_data;
      end
    end
  end

  ssb_fwd #(
    .DEPTH  (DEPTH),
    .INUM_W (INUM_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .live     (live),
    .e_inum   (inum_q),
    .e_tag    (tag_q),
    .e_data   (data_q),
    .head_idx (head_idx),
    .lk_valid (ld_valid),
    .lk_tag   (ld_tag),
    .lk_inum  (ld_inum),
    .hit      (ld_hit),
    .data     (ld_data)
  );
endmodule

// File: rtl/spec_store_buf_chk.sv
module spec_store_buf_chk #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              cw_valid,
  input logic              cw_ready,
  input logic [TAG_W-1:0]  cw_tag,
  input logic [DATA_W-1:0] cw_data,
  input logic              ld_valid,
  input logic              ld_hit
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)) ||
             ($past(cnt) == cnt + CNT_W'(1)));

  a_r4_write_needs_entry: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> (cnt != '0));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && !cw_ready) |=> cw_valid && $stable(cw_tag) && $stable(cw_data));

  a_r8_hit_after_probe: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> $past(ld_valid));
endmodule

bind spec_store_buf spec_store_buf_chk #(
  .DEPTH  (DEPTH),
  .TAG_W  (TAG_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (cnt),
  .cw_valid (cw_valid),
  .cw_ready (cw_ready),
  .cw_tag   (cw_tag),
  .cw_data  (cw_data),
  .ld_valid (ld_valid),
  .ld_hit   (ld_hit)
);

// File: tb/sim_spec_store_buf.sv
`timescale 1ns/1ps
module sim_spec_store_buf;
  localparam int INUM_W = 6;
  localparam int TAG_W  = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              st_valid = 0, cm_valid = 0, ab_valid = 0, ab_younger = 0;
  logic              ld_valid = 0, cw_ready = 0;
  logic [INUM_W-1:0] st_inum = 0, cm_inum = 0, ab_inum = 0, ld_inum = 0;
  logic [TAG_W-1:0]  st_tag = 0, ld_tag = 0;
  logic [DATA_W-1:0] st_data = 0;
  logic              st_full, ld_hit, cw_valid;
  logic [DATA_W-1:0] ld_data, cw_data;
  logic [TAG_W-1:0]  cw_tag;

  spec_store_buf u0 (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_inum(st_inum), .st_tag(st_tag), .st_data(st_data),
    .st_full(st_full),
    .cm_valid(cm_valid), .cm_inum(cm_inum),
    .ab_valid(ab_valid), .ab_inum(ab_inum), .ab_younger(ab_younger),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_inum(ld_inum),
    .ld_hit(ld_hit), .ld_data(ld_data),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_tag(cw_tag), .cw_data(cw_data)
  );

  int tests = 0;
  int fails = 0;
  int nlog  = 0;
  logic [TAG_W-1:0]  log_tag  [32];
  logic [DATA_W-1:0] log_data [32];

  // cache write log, sampled mid-cycle after the bench drives at the falling edge
  always begin
    @(negedge clk);
    #1;
    if (!rst && cw_valid && cw_ready && nlog < 32) begin
      log_tag[nlog]  = cw_tag;
      log_data[nlog] = cw_data;
      nlog++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [INUM_W-1:0] n, input logic [TAG_W-1:0] t,
                          input logic [DATA_W-1:0] d);
    @(negedge clk);
    st_valid = 1; st_inum = n; st_tag = t; st_data = d;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic do_commit(input logic [INUM_W-1:0] n);
    @(negedge clk);
    cm_valid = 1; cm_inum = n;
    @(negedge clk);
    cm_valid = 0;
  endtask

  task automatic do_abort(input logic [INUM_W-1:0] n, input logic yng);
    @(negedge clk);
    ab_valid = 1; ab_inum = n; ab_younger = yng;
    @(negedge clk);
    ab_valid = 0;
  endtask

  // probe driven at one falling edge, result registered at the next rising edge
  task automatic probe(input logic [TAG_W-1:0] t, input logic [INUM_W-1:0] n,
                       input logic exp_hit, input logic [DATA_W-1:0] exp_d, input string req);
    @(negedge clk);
    ld_valid = 1; ld_tag = t; ld_inum = n;
    @(negedge clk);
    ld_valid = 0;
    check({req, " hit"}, 32'(ld_hit), 32'(exp_hit));
    if (exp_hit) check({req, " data"}, 32'(ld_data), 32'(exp_d));
  endtask

  // {tag, load inum, expected hit, expected data}
  localparam int NVEC = 10;
  localparam logic [30:0] VEC [NVEC] = '{
    {8'h11, 6'd11, 1'b1, 16'hA010},  // R8 single older match
    {8'h11, 6'd15, 1'b1, 16'hA014},  // R10 youngest of 10 and 14
    {8'h11, 6'd14, 1'b1, 16'hA010},  // R9 same number not forwarded
    {8'h11, 6'd10, 1'b0, 16'h0000},  // R9 no strictly older store
    {8'h22, 6'd13, 1'b1, 16'hA012},  // R8
    {8'h22, 6'd12, 1'b0, 16'h0000},  // R9
    {8'h33, 6'd20, 1'b1, 16'hA016},  // R8
    {8'h44, 6'd20, 1'b0, 16'h0000},  // R8 tag miss
    {8'h11, 6'd40, 1'b1, 16'hA014},  // R11 far but within half range
    {8'h11, 6'd9,  1'b0, 16'h0000}   // R9 load older than all
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 st_full", 32'(st_full), 0);
    check("R1 cw_valid", 32'(cw_valid), 0);
    check("R1 ld_hit", 32'(ld_hit), 0);

    // speculative stores
    do_store(6'd10, 8'h11, 16'hA010);
    do_store(6'd12, 8'h22, 16'hA012);
    do_store(6'd14, 8'h11, 16'hA014);
    do_store(6'd16, 8'h33, 16'hA016);

    for (int i = 0; i < NVEC; i++)
      probe(VEC[i][30:23], VEC[i][22:17], VEC[i][16], VEC[i][15:0], "R8 R9 R10 R11 vec");

    // R3: nothing speculative leaves even with the port ready
    @(negedge clk); cw_ready = 1;
    repeat (3) @(negedge clk);
    check("R3 no spec write", 32'(cw_valid), 0);
    check("R3 log empty", 32'(nlog), 0);
    cw_ready = 0;

    // R6: single abort of 14
    do_abort(6'd14, 1'b0);
    probe(8'h11, 6'd15, 1'b1, 16'hA010, "R6 aborted store skipped");

    // R4/R5/R12: commit head while port stalls
    do_commit(6'd10);
    check("R4 head offered", 32'(cw_valid), 1);
    check("R4 head tag", 32'(cw_tag), 32'h11);
    check("R4 head data", 32'(cw_data), 32'hA010);
    repeat (3) @(negedge clk);
    check("R5 held valid", 32'(cw_valid), 1);
    check("R5 held data", 32'(cw_data), 32'hA010);
    probe(8'h11, 6'd11, 1'b1, 16'hA010, "R12 committed still forwards");
    do_commit(6'd12);
    do_commit(6'd16);
    @(negedge clk); cw_ready = 1;
    repeat (8) @(negedge clk);
    check("R4 R6 write count", 32'(nlog), 3);
    check("R4 order 0", 32'(log_data[0]), 32'hA010);
    check("R4 order 1", 32'(log_data[1]), 32'hA012);
    check("R4 order 2", 32'(log_data[2]), 32'hA016);
    check("R4 order 2 tag", 32'(log_tag[2]), 32'h33);
    probe(8'h11, 6'd11, 1'b0, 16'h0, "R4 drained entry gone");

    // R7: abort 22 and younger
    base = nlog;
    cw_ready = 0;
    do_store(6'd20, 8'h50, 16'hB020);
    do_store(6'd21, 8'h51, 16'hB021);
    do_store(6'd22, 8'h52, 16'hB022);
    do_store(6'd23, 8'h53, 16'hB023);
    do_abort(6'd22, 1'b1);
    probe(8'h52, 6'd30, 1'b0, 16'h0, "R7 aborted 22");
    probe(8'h53, 6'd30, 1'b0, 16'h0, "R7 aborted 23");
    probe(8'h51, 6'd30, 1'b1, 16'hB021, "R7 kept 21");
    do_commit(6'd20);
    do_commit(6'd21);
    @(negedge clk); cw_ready = 1;
    repeat (8) @(negedge clk);
    check("R7 write count", 32'(nlog - base), 2);
    check("R7 first", 32'(log_data[base]), 32'hB020);
    check("R7 second", 32'(log_data[base+1]), 32'hB021);

    // R2/R11: fill across the number wrap
    base = nlog;
    cw_ready = 0;
    for (int i = 0; i < 8; i++) begin
      automatic logic [INUM_W-1:0] n = INUM_W'(60 + i);
      automatic logic [TAG_W-1:0]  t = (i == 2 || i == 5) ? 8'h99 : TAG_W'(8'h70 + i);
      do_store(n, t, {10'h300, n});
    end
    check("R2 full after 8", 32'(st_full), 1);
    do_store(6'd4, 8'h7F, 16'hC004);
    probe(8'h7F, 6'd10, 1'b0, 16'h0, "R2 dropped when full");
    probe(8'h99, 6'd2, 1'b1, 16'hC001, "R11 youngest across wrap");
    probe(8'h99, 6'd0, 1'b1, 16'hC03E, "R11 older side of wrap");
    for (int i = 0; i < 8; i++) do_commit(INUM_W'(60 + i));
    @(negedge clk); cw_ready = 1;
    repeat (12) @(negedge clk);
    check("R2 full cleared", 32'(st_full), 0);
    check("R2 R4 write count", 32'(nlog - base), 8);
    for (int i = 0; i < 8; i++) begin
      automatic logic [INUM_W-1:0] n = INUM_W'(60 + i);
      check("R4 R11 wrap order", 32'(log_data[base+i]), 32'({10'h300, n}));
    end
    probe(8'h99, 6'd2, 1'b0, 16'h0, "R4 all drained");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule